// File: doc/BRIEF.md
# Two-Level Eight-Source Interrupt Arbiter

This block sits beside an 8-bit microcontroller core and decides which of eight interrupt sources is served next. Four sources are external pins (active low). The other four are internal event lines from timer 0, timer 1, the serial port and timer 2. Each source has an enable bit and a priority bit, and one global enable gates everything. The winning request is shown to the core as `irq` together with a vector address.

The core pulses `ack` when it takes the interrupt. The arbiter then latches the vector and records which priority level is now in service. A high-level request may interrupt a low-level handler. Any other request waits until the core pulses `reti`.

Each external pin passes through a two-flop synchroniser. It is then treated either as falling-edge triggered, with a flag that the hardware sets and clears, or as low-level triggered. The two extra external inputs (ext2, ext3) take their controls from one packed control byte.

Top module: `irq_arbiter8`

## Requirements
- R1: Source index k (0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2, 6 ext2, 7 ext3) presents vector 8*k+3, that is 03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 33h, 3Bh.
- R2: Among pending requests of equal priority level, the lowest source index wins.
- R3: A pending high-level request wins over every low-level request, whatever their indices.
- R4: A source requests only when its own enable bit and `gbl_en` are both 1; otherwise `irq` stays 0 for it.
- R5: In edge mode (type bit 1) a falling edge on the pin sets the source's flag. The flag stays set after the pin returns high, and it is cleared when that source is acknowledged.
- R6: In level mode (type bit 0) the source requests exactly while its synchronised pin is low. Nothing is latched, so `ext_flag` follows the pin.
- R7: While only a low-level handler is in service, low-level requests are held off, and a high-level request still raises `irq`.
- R8: While a high-level handler is in service, `irq` stays 0.
- R9: `reti` ends the high-level service if it is active, and otherwise ends the low-level service. `ack` with `irq` low changes nothing.
- R10: After reset, `irq`, `in_service`, `svc_vector` and `ext_flag` are all 0.
- R11: `xctl` bits, MSB to LSB: [7] ext3 priority, [6] ext3 enable, [5] unused (flag is read on `ext_flag[3]`), [4] ext3 type, [3] ext2 priority, [2] ext2 enable, [1] unused (flag on `ext_flag[2]`), [0] ext2 type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gbl_en | input | 1 | Global interrupt enable |
| src_en | input | 6 | Enables for sources 0..5 |
| src_pri | input | 6 | Priority bits for sources 0..5 (1 = high) |
| ext01_type | input | 2 | Type bits for ext0, ext1 (1 = falling edge) |
| xctl | input | 8 | Packed control for ext2/ext3 (see R11) |
| ext_n | input | 4 | External pins ext0..ext3, active low |
| evt_req | input | 4 | Internal requests: timer0, timer1, serial, timer2 |
| ack | input | 1 | Core accepts the presented interrupt |
| reti | input | 1 | Core returns from a handler |
| irq | output | 1 | A request is presented |
| vector | output | 8 | Vector of the presented request |
| svc_vector | output | 8 | Vector latched at the last acknowledge |
| in_service | output | 2 | [1] high level active, [0] low level active |
| ext_flag | output | 4 | Detection state of ext0..ext3 |

## Verification
The hardest situation to reach from the ports is nested service. A low-level handler has to be in service while a high-level request arrives and is acknowledged. Low requests are kept pending the whole time, so the bench can see them held off at each step. The bench reaches it by holding several requests at once, acknowledging in sequence, and then unwinding with two `reti` pulses, checking `irq` and `in_service` after each pulse. It also sweeps every request mask against several priority masks, with the pins in level mode, to cover the polling order.

// File: rtl/irq_arbiter8.sv
module irq_arbiter8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gbl_en,
  input  logic [5:0] src_en,
  input  logic [5:0] src_pri,
  input  logic [1:0] ext01_type,
  input  logic [7:0] xctl,
  input  logic [3:0] ext_n,
  input  logic [3:0] evt_req,
  input  logic       ack,
  input  logic       reti,
  output logic       irq,
  output logic [7:0] vector,
  output logic [7:0] svc_vector,
  output logic [1:0] in_service,
  output logic [3:0] ext_flag
);
  logic [3:0] s1, s2, s3, flag_q, ext_type, fall, clr;
  logic [7:0] en8, pri8, req8, pend, hi, lo, cand;
  logic [2:0] win;
  logic       allow_hi, allow_lo;

  assign ext_type = {xctl[4], xctl[0], ext01_type};
  assign en8      = {xctl[6], xctl[2], src_en};
  assign pri8     = {xctl[7], xctl[3], src_pri};
  assign fall     = s3 & ~s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1; s2 <= '1; s3 <= '1;
    end else begin
      s1 <= ext_n; s2 <= s1; s3 <= s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else
      for (int k = 0; k < 4; k++)
        if (!ext_type[k])  flag_q[k] <= 1'b0;
        else if (fall[k])  flag_q[k] <= 1'b1;
        else if (clr[k])   flag_q[k] <= 1'b0;

  assign ext_flag = (ext_type & flag_q) | (~ext_type & ~s2);
  assign req8 = {ext_flag[3], ext_flag[2], evt_req[3], evt_req[2],
                 evt_req[1], ext_flag[1], evt_req[0], ext_flag[0]};

  assign pend     = req8 & en8 & {8{gbl_en}};
  assign hi       = pend & pri8;
  assign lo       = pend & ~pri8;
  assign allow_hi = !in_service[1];
  assign allow_lo = !in_service[1] && !in_service[0];
  assign cand     = (allow_hi && |hi) ? hi : (allow_lo ? lo : 8'h00);

  always_comb begin
    win = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (cand[i]) win = 3'(i);
  end

  assign irq    = |cand;
  assign vector = {2'b00, win, 3'b011};

  always_comb begin
    clr = '0;
    if (ack && irq)
      case (win)
        3'd0: clr[0] = 1'b1;
        3'd2: clr[1] = 1'b1;
        3'd6: clr[2] = 1'b1;
        3'd7: clr[3] = 1'b1;
        default: clr = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_service <= 2'b00;
      svc_vector <= 8'h00;
    end else begin
      if (reti) begin
        if (in_service[1]) in_service[1] <= 1'b0;
        else               in_service[0] <= 1'b0;
      end
      if (ack && irq) begin
        svc_vector <= vector;
        if (pri8[win]) in_service[1] <= 1'b1;
        else           in_service[0] <= 1'b1;
      end
    end
endmodule

module irq_arbiter8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gbl_en,
  input logic [5:0] src_pri,
  input logic [1:0] ext01_type,
  input logic [7:0] xctl,
  input logic       ack,
  input logic       reti,
  input logic       irq,
  input logic [7:0] vector,
  input logic [1:0] in_service,
  input logic [3:0] ext_flag
);
  logic [7:0] pri_all;
  assign pri_all = {xctl[7], xctl[3], src_pri};

  a_r1_vector_form: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vector[2:0] == 3'b011 && vector[7:6] == 2'b00));
  a_r4_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gbl_en);
  a_r8_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_service[1] |-> !irq);
  a_r7_low_preempt_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service[0] && irq) |-> pri_all[vector[5:3]]);
  a_r9_reti_top: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && in_service == 2'b11) |=> in_service == 2'b01);
  a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_flag[0] && ext01_type[0] && !ack) |=> (ext_flag[0] || !ext01_type[0]));
endmodule

bind irq_arbiter8 irq_arbiter8_chk chk (
  .clk(clk), .rst_n(rst_n), .gbl_en(gbl_en), .src_pri(src_pri),
  .ext01_type(ext01_type), .xctl(xctl), .ack(ack), .reti(reti),
  .irq(irq), .vector(vector), .in_service(in_service), .ext_flag(ext_flag));

// File: tb/irq_arbiter8_test.sv
`timescale 1ns/1ps
module irq_arbiter8_test;
  logic clk = 0, rst_n = 0, gbl_en = 0, ack = 0, reti = 0;
  logic [5:0] src_en = 0, src_pri = 0;
  logic [1:0] ext01_type = 0;
  logic [7:0] xctl = 0;
  logic [3:0] ext_n = 4'hF, evt_req = 0;
  logic irq;
  logic [7:0] vector, svc_vector;
  logic [1:0] in_service;
  logic [3:0] ext_flag;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_arbiter8 uut (.clk(clk), .rst_n(rst_n), .gbl_en(gbl_en), .src_en(src_en),
    .src_pri(src_pri), .ext01_type(ext01_type), .xctl(xctl), .ext_n(ext_n),
    .evt_req(evt_req), .ack(ack), .reti(reti), .irq(irq), .vector(vector),
    .svc_vector(svc_vector), .in_service(in_service), .ext_flag(ext_flag));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(logic [7:0] m);
    src_en = m[5:0]; xctl[2] = m[6]; xctl[6] = m[7];
  endtask

  task automatic set_pri(logic [7:0] m);
    src_pri = m[5:0]; xctl[3] = m[6]; xctl[7] = m[7];
  endtask

  task automatic set_req(logic [7:0] m);
    ext_n   = ~{m[7], m[6], m[2], m[0]};
    evt_req = {m[5], m[4], m[3], m[1]};
    cyc(3);
  endtask

  task automatic pulse_ack();
    ack = 1; cyc(1); ack = 0;
  endtask

  task automatic pulse_reti();
    reti = 1; cyc(1); reti = 0;
  endtask

  function automatic int exp_win(logic [7:0] r, logic [7:0] p);
    for (int i = 0; i < 8; i++) if (r[i] && p[i]) return i;
    for (int i = 0; i < 8; i++) if (r[i]) return i;
    return -1;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(2);
    chk("R10 irq", irq, 0); chk("R10 in_service", in_service, 0);
    chk("R10 svc_vector", svc_vector, 0); chk("R10 ext_flag", ext_flag, 0);
    rst_n = 1; cyc(1);

    gbl_en = 1; set_en(8'hFF);
    // R1 single sources, R11 ext2/ext3 enables via xctl
    for (int k = 0; k < 8; k++) begin
      set_req(8'(1 << k));
      chk("R1 irq", irq, 1); chk("R1 vector", vector, 8 * k + 3);
    end
    // R2/R3 sweep of masks over priority patterns
    for (int pp = 0; pp < 4; pp++) begin
      logic [7:0] p;
      p = (pp == 0) ? 8'h00 : (pp == 1) ? 8'hC0 : (pp == 2) ? 8'h2A : 8'h81;
      set_pri(p);
      for (int m = 0; m < 256; m++) begin
        int w;
        set_req(8'(m));
        w = exp_win(8'(m), p);
        if (w < 0) chk("R2 idle", irq, 0);
        else begin
          chk(p == 0 ? "R2 order" : "R3 level", vector, 8 * w + 3);
          chk("R2 irq", irq, 1);
        end
      end
    end
    set_pri(0);
    // R4 gating
    set_req(8'h12);
    gbl_en = 0; cyc(1); chk("R4 global off", irq, 0);
    gbl_en = 1; set_en(8'hFD); cyc(1); chk("R4 src disable", vector, 8'h23);
    set_en(8'hED); cyc(1); chk("R4 both disabled", irq, 0);
    set_en(8'hFF); set_req(0);

    // R5 edge mode on ext0 and ext3
    ext01_type = 2'b01; xctl[4] = 1; cyc(2);
    chk("R5 no flag yet", ext_flag, 0);
    ext_n[0] = 0; cyc(2); ext_n[0] = 1; cyc(3);
    chk("R5 flag kept", ext_flag[0], 1); chk("R5 irq", vector, 8'h03);
    pulse_ack();
    chk("R5 flag cleared", ext_flag[0], 0); chk("R5 svc", svc_vector, 8'h03);
    chk("R5 in_service lo", in_service, 2'b01);
    pulse_reti(); chk("R9 reti lo", in_service, 0);
    ext_n[3] = 0; cyc(4); chk("R5 ext3 flag", ext_flag[3], 1);
    chk("R5 ext3 vector", vector, 8'h3B);
    ext_n[3] = 1; pulse_ack(); cyc(3);
    chk("R5 ext3 cleared", ext_flag[3], 0);
    pulse_reti();
    ext01_type = 0; xctl[4] = 0; cyc(1);

    // R6 level mode
    ext_n[1] = 0; cyc(3); chk("R6 level req", vector, 8'h13);
    chk("R6 flag follows", ext_flag[1], 1);
    ext_n[1] = 1; cyc(3); chk("R6 released", irq, 0);
    chk("R6 no latch", ext_flag[1], 0);

    // R7/R8/R9 nesting
    ack = 1; cyc(1); ack = 0; chk("R9 ack w/o irq", in_service, 0);
    set_pri(8'h20);
    set_req(8'h0A);
    pulse_ack(); chk("R7 lo serving", in_service, 2'b01);
    chk("R7 svc vec", svc_vector, 8'h0B);
    chk("R7 low held", irq, 0);
    evt_req[3] = 1; cyc(1);
    chk("R7 high preempts", irq, 1); chk("R7 vec", vector, 8'h2B);
    pulse_ack(); chk("R8 both", in_service, 2'b11);
    chk("R8 quiet", irq, 0);
    pulse_reti(); chk("R9 top first", in_service, 2'b01);
    chk("R7 high again", vector, 8'h2B);
    evt_req[3] = 0; cyc(1); chk("R7 low still held", irq, 0);
    pulse_reti(); chk("R9 all done", in_service, 0);
    chk("R2 low resumes", vector, 8'h0B);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule